// File: doc/BRIEF.md
# MAC Merge Verification Controller

This controller runs the handshake that proves a link partner can accept preempted traffic before frame preemption is switched on. While verification is enabled and the link is up, it asks the transmit path to send verify mPackets. The requests are paced by a programmable interval timer, and only a bounded number of them go out. It watches for the partner's response and turns preemption on only once that response has arrived. Independently of its own progress, it asks for a response mPacket whenever the partner's verify mPacket is received, provided the preemptable MAC is enabled.

When verification is disabled, no handshake runs. The preemption enable then simply follows the transmit enable while the link is up. When the link drops, preemption and the timer stop. A new link, or a fresh enabling of verification, restarts the sequence from the beginning with a full attempt budget. The mPacket framing and the datapath lie outside this block. It only issues one-cycle request strobes and consumes one-cycle event strobes.

Top module: `mmv_ctrl`

## Requirements
- R1: The status code is 0 = disabled, 1 = initial, 2 = verifying, 3 = succeeded, 4 = failed. After reset the status is 0 and every output is low.
- R2: While verify_en_i is low, the status is 0 and no verify request is issued. preempt_en_o equals link_up_i AND tx_en_i as sampled on the previous clock edge.
- R3: With verify_en_i high, a restart happens in either of two cases: link_up_i rises while pmac_en_i is high, or verify_en_i rises. A restart sets the status to 1 and refills the attempt budget to MAX_TRIES. The first verify request is issued one cycle after the restart, as long as link, pmac, transmit and verify are all enabled.
- R4: While armed in status 1 or 2, verify requests are spaced interval_i cycles apart. A value of 0 counts as 1.
- R5: After MAX_TRIES requests, the next timer expiry sets the status to 4. No further verify request is issued.
- R6: A verify-transmitted event sets the status to 2 unless the status is 3.
- R7: A received response moves the status from 2 to 3. In any other status it is ignored.
- R8: In status 3, preempt_en_o is high while the link is up and tx_en_i is high. The timer stops and no verify request follows.
- R9: A received verify event while pmac_en_i is high produces a one-cycle send_resp_o on the next cycle.
- R10: While pmac_en_i is low, all event strobes are ignored and the timer is paused. The remaining budget is kept, and when the timer is re-armed the next request goes out on the following cycle.
- R11: While link_up_i is low, preempt_en_o, irq_en_o and send_verify_o stay low on the next cycle, and the timer stops.
- R12: irq_en_o equals link_up_i AND pmac_en_i as sampled on the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up_i | input | 1 | Link is up |
| pmac_en_i | input | 1 | Preemptable MAC enabled |
| tx_en_i | input | 1 | Preemption wanted on transmit |
| verify_en_i | input | 1 | Run the verification handshake |
| interval_i | input | TIMER_W | Cycles between verify attempts |
| ver_tx_i | input | 1 | Strobe: local verify mPacket was sent |
| ver_rx_i | input | 1 | Strobe: partner verify mPacket received |
| rsp_rx_i | input | 1 | Strobe: partner response mPacket received |
| send_verify_o | output | 1 | Request: send one verify mPacket |
| send_resp_o | output | 1 | Request: send one response mPacket |
| preempt_en_o | output | 1 | Frame preemption enabled |
| irq_en_o | output | 1 | Preemption event interrupt enabled |
| status_o | output | 3 | Verification status code |

## Verification
The handshake is tried under four patterns:
- A partner that never answers shows the exact spacing of the attempts and the point where the budget runs out into failure.
- A partner that answers, but only after a stray early response, separates "response ignored outside verifying" from "response completes verification".
- A pause of the preemptable MAC in mid-handshake, followed by a link drop, shows that events are ignored and that the timer is held while the budget is kept.
- A run with verification disabled confirms that preemption follows the transmit enable directly, with no request traffic.

The partner's verify is sent both with and without the preemptable MAC enabled, so the automatic response can be told apart from a spurious one.

// File: rtl/mmv_pkg.sv
package mmv_pkg;
   typedef enum logic [2:0] {
      MM_DISABLED  = 3'd0,
      MM_INITIAL   = 3'd1,
      MM_VERIFYING = 3'd2,
      MM_SUCCEEDED = 3'd3,
      MM_FAILED    = 3'd4
   } mm_state_e;
endpackage

// File: rtl/mmv_pace_timer.sv
// Interval timer: fires immediately when armed, then every max(interval,1) cycles.
module mmv_pace_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm_i,
   input  logic [CNT_W-1:0] interval_i,
   output logic             tick_o
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] reload;

   assign reload = (interval_i == '0) ? '0 : interval_i - CNT_W'(1);
   assign tick_o = arm_i && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (!arm_i)         cnt_q <= '0;
      else if (cnt_q == '0)    cnt_q <= reload;
      else                     cnt_q <= cnt_q - CNT_W'(1);
   end
endmodule

// File: rtl/mmv_retry_budget.sv
// Attempt budget: refilled on load, decremented per attempt taken.
module mmv_retry_budget #(
   parameter int MAX_TRIES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic take_i,
   output logic empty_o
);
   localparam int RW = $clog2(MAX_TRIES + 1);
   logic [RW-1:0] left_q;

   assign empty_o = (left_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)                  left_q <= RW'(MAX_TRIES);
      else if (load_i)             left_q <= RW'(MAX_TRIES);
      else if (take_i && !empty_o) left_q <= left_q - RW'(1);
   end
endmodule

// File: rtl/mmv_resp_echo.sv
// Answers a partner verify with a response request, gated by the pMAC enable.
module mmv_resp_echo #(
   parameter bit REGISTERED = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pmac_en_i,
   input  logic ver_rx_i,
   output logic resp_o
);
   logic want;
   assign want = pmac_en_i && ver_rx_i;

   generate
      if (REGISTERED) begin : g_reg
         logic resp_q;
         always_ff @(posedge clk) begin
            if (!rst_n) resp_q <= 1'b0;
            else        resp_q <= want;
         end
         assign resp_o = resp_q;
      end else begin : g_comb
         assign resp_o = want;
      end
   endgenerate
endmodule

// File: rtl/mmv_ctrl.sv
module mmv_ctrl
   import mmv_pkg::*;
#(
   parameter int TIMER_W   = 16,
   parameter int MAX_TRIES = 3,
   parameter bit RESP_REG  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               link_up_i,
   input  logic               pmac_en_i,
   input  logic               tx_en_i,
   input  logic               verify_en_i,
   input  logic [TIMER_W-1:0] interval_i,
   input  logic               ver_tx_i,
   input  logic               ver_rx_i,
   input  logic               rsp_rx_i,
   output logic               send_verify_o,
   output logic               send_resp_o,
   output logic               preempt_en_o,
   output logic               irq_en_o,
   output logic [2:0]         status_o
);
   generate
      if (TIMER_W < 2 || TIMER_W > 32) begin : g_bad_timer_w
         $error("mmv_ctrl: TIMER_W must lie in 2..32");
      end
      if (MAX_TRIES < 1 || MAX_TRIES > 255) begin : g_bad_tries
         $error("mmv_ctrl: MAX_TRIES must lie in 1..255");
      end
   endgenerate

   mm_state_e status_q, status_d;
   logic link_q, ven_q;
   logic restart, live, arm, tick, empty;
   logic send_d, take, send_q, preempt_q, irq_q;

   assign restart = verify_en_i &&
                    ((link_up_i && !link_q && pmac_en_i) || !ven_q);
   assign live    = (status_q == MM_INITIAL) || (status_q == MM_VERIFYING);
   assign arm     = link_up_i && pmac_en_i && tx_en_i && verify_en_i &&
                    live && !restart;

   mmv_pace_timer #(.CNT_W(TIMER_W)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .arm_i      (arm),
      .interval_i (interval_i),
      .tick_o     (tick)
   );

   mmv_retry_budget #(.MAX_TRIES(MAX_TRIES)) u_budget (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (restart),
      .take_i  (take),
      .empty_o (empty)
   );

   mmv_resp_echo #(.REGISTERED(RESP_REG)) u_echo (
      .clk       (clk),
      .rst_n     (rst_n),
      .pmac_en_i (pmac_en_i),
      .ver_rx_i  (ver_rx_i),
      .resp_o    (send_resp_o)
   );

   // Next status: events first, then timer expiry on the updated status.
   always_comb begin
      status_d = status_q;
      send_d   = 1'b0;
      take     = 1'b0;
      if (!verify_en_i) begin
         status_d = MM_DISABLED;
      end else if (restart) begin
         status_d = MM_INITIAL;
      end else begin
         if (pmac_en_i && ver_tx_i && status_d != MM_SUCCEEDED)
            status_d = MM_VERIFYING;
         if (pmac_en_i && rsp_rx_i && status_d == MM_VERIFYING)
            status_d = MM_SUCCEEDED;
         if (tick && (status_d == MM_INITIAL || status_d == MM_VERIFYING)) begin
            if (!empty) begin
               send_d = 1'b1;
               take   = 1'b1;
            end else begin
               status_d = MM_FAILED;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_q  <= MM_DISABLED;
         link_q    <= 1'b0;
         ven_q     <= 1'b0;
         send_q    <= 1'b0;
         preempt_q <= 1'b0;
         irq_q     <= 1'b0;
      end else begin
         status_q  <= status_d;
         link_q    <= link_up_i;
         ven_q     <= verify_en_i;
         send_q    <= send_d;
         preempt_q <= link_up_i && tx_en_i &&
                      (!verify_en_i || status_d == MM_SUCCEEDED);
         irq_q     <= link_up_i && pmac_en_i;
      end
   end

   assign send_verify_o = send_q;
   assign preempt_en_o  = preempt_q;
   assign irq_en_o      = irq_q;
   assign status_o      = status_q;
endmodule

// File: rtl/mmv_ctrl_chk.sv
module mmv_ctrl_chk #(
   parameter bit RESP_REG = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       link_up_i,
   input logic       pmac_en_i,
   input logic       tx_en_i,
   input logic       verify_en_i,
   input logic       ver_rx_i,
   input logic       rsp_rx_i,
   input logic       send_verify_o,
   input logic       send_resp_o,
   input logic       preempt_en_o,
   input logic       irq_en_o,
   input logic [2:0] status_o
);
   // R2: verification off forces the disabled code
   p_off_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(verify_en_i) |-> status_o == 3'd0);

   // R4: a verify request needs every enable on the cycle it was decided
   p_verify_armed_r4: assert property (@(posedge clk) disable iff (!rst_n)
      send_verify_o |-> $past(link_up_i && pmac_en_i && tx_en_i && verify_en_i));

   // R5: no verify request once failed
   p_failed_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      status_o == 3'd4 |-> !send_verify_o);

   // R7: success is only entered on a response seen with pMAC enabled
   p_success_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o == 3'd3 && $past(status_o) != 3'd3) |-> $past(rsp_rx_i && pmac_en_i));

   // R8: preemption requires transmit enable
   p_preempt_tx_r8: assert property (@(posedge clk) disable iff (!rst_n)
      preempt_en_o |-> $past(tx_en_i));

   // R11: link down silences preemption, interrupt enable and verify requests
   p_link_down_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(link_up_i) |-> (!preempt_en_o && !irq_en_o && !send_verify_o));

   generate
      if (RESP_REG) begin : g_resp_chk
         // R9: a response request follows a partner verify seen with pMAC enabled
         p_resp_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
            send_resp_o |-> $past(ver_rx_i && pmac_en_i));
      end
   endgenerate
endmodule

bind mmv_ctrl mmv_ctrl_chk #(.RESP_REG(RESP_REG)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .link_up_i     (link_up_i),
   .pmac_en_i     (pmac_en_i),
   .tx_en_i       (tx_en_i),
   .verify_en_i   (verify_en_i),
   .ver_rx_i      (ver_rx_i),
   .rsp_rx_i      (rsp_rx_i),
   .send_verify_o (send_verify_o),
   .send_resp_o   (send_resp_o),
   .preempt_en_o  (preempt_en_o),
   .irq_en_o      (irq_en_o),
   .status_o      (status_o)
);

// File: tb/mmv_ctrl_bench.sv
`timescale 1ns/1ps
module mmv_ctrl_bench;
   localparam int TW = 16;
   localparam int TRIES = 3;
   localparam int N = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic link_up = 0, pmac_en = 0, tx_en = 0, verify_en = 0;
   logic ver_tx = 0, ver_rx = 0, rsp_rx = 0;
   logic [TW-1:0] interval = TW'(N);
   logic send_verify, send_resp, preempt_en, irq_en;
   logic [2:0] status;

   always #2 clk = ~clk;

   mmv_ctrl #(.TIMER_W(TW), .MAX_TRIES(TRIES), .RESP_REG(1'b1)) u_mmv_ctrl (
      .clk(clk), .rst_n(rst_n), .link_up_i(link_up), .pmac_en_i(pmac_en),
      .tx_en_i(tx_en), .verify_en_i(verify_en), .interval_i(interval),
      .ver_tx_i(ver_tx), .ver_rx_i(ver_rx), .rsp_rx_i(rsp_rx),
      .send_verify_o(send_verify), .send_resp_o(send_resp),
      .preempt_en_o(preempt_en), .irq_en_o(irq_en), .status_o(status));

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct { int kind; int at; } item_t;   // kind 0 verify, 1 response
   item_t exp_q[$];
   int n_chk = 0, n_bad = 0;

   task automatic chk(string req, int act, int expv);
      n_chk++;
      if (act != expv) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
      end
   endtask

   task automatic expect_req(int kind, int at);
      exp_q.push_back('{kind: kind, at: at});
   endtask

   task automatic match(int kind);
      item_t it;
      n_chk++;
      if (exp_q.size() == 0) begin
         n_bad++;
         $display("FAIL R4/R9 unexpected request: actual kind %0d at %0d expected none", kind, cyc);
      end else begin
         it = exp_q.pop_front();
         if (it.kind != kind || it.at != cyc) begin
            n_bad++;
            $display("FAIL R4/R9 request: actual kind %0d at %0d expected kind %0d at %0d",
                     kind, cyc, it.kind, it.at);
         end
      end
   endtask

   // Monitor: compares each produced request against the scoreboard queue
   always @(negedge clk) begin
      if (rst_n) begin
         if (send_verify) match(0);
         if (send_resp)   match(1);
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
   end

   initial begin
      int c0;
      step(3);
      rst_n = 1'b1;
      step(1);
      // R1 reset state
      chk("R1 status", status, 0);
      chk("R1 preempt", preempt_en, 0);
      chk("R1 irq", irq_en, 0);

      // R2 verification disabled: preemption follows tx enable
      link_up = 1; pmac_en = 1; tx_en = 1;
      step(1);
      chk("R2 preempt follows tx", preempt_en, 1);
      chk("R2 status", status, 0);
      chk("R12 irq", irq_en, 1);
      tx_en = 0;
      step(1);
      chk("R2 preempt off", preempt_en, 0);
      tx_en = 1;
      step(2);

      // R3/R4/R5 silent partner: three paced attempts, then failure
      verify_en = 1; c0 = cyc;
      expect_req(0, c0 + 2);
      expect_req(0, c0 + 2 + N);
      expect_req(0, c0 + 2 + 2*N);
      step(1);
      chk("R3 restart to initial", status, 1);
      step(3*N);
      chk("R5 not failed before last expiry", status, 1);
      step(1);
      chk("R5 failed", status, 4);
      chk("R8 no preempt when failed", preempt_en, 0);
      step(3*N);
      chk("R5 no further attempts", exp_q.size(), 0);

      // R11 link down
      link_up = 0;
      step(1);
      chk("R11 preempt low", preempt_en, 0);
      chk("R11 irq low", irq_en, 0);

      // R6/R7/R8 answering partner
      link_up = 1; c0 = cyc;
      expect_req(0, c0 + 2);
      step(2);
      rsp_rx = 1; step(1); rsp_rx = 0;
      chk("R7 response ignored in initial", status, 1);
      ver_tx = 1; step(1); ver_tx = 0;
      chk("R6 verify sent -> verifying", status, 2);
      rsp_rx = 1; step(1); rsp_rx = 0;
      chk("R7 response -> succeeded", status, 3);
      chk("R8 preempt on", preempt_en, 1);
      chk("R12 irq on", irq_en, 1);
      step(3*N);
      chk("R8 timer stopped", exp_q.size(), 0);
      ver_tx = 1; step(1); ver_tx = 0;
      chk("R6 succeeded kept", status, 3);

      // R9 partner verify answered only with pMAC enabled
      ver_rx = 1; expect_req(1, cyc + 1); step(1); ver_rx = 0;
      step(1);
      chk("R9 response issued", exp_q.size(), 0);
      pmac_en = 0;
      ver_rx = 1; step(1); ver_rx = 0;
      step(2);
      pmac_en = 1;
      step(1);

      // R10/R11 pause and link drop mid-handshake
      link_up = 0; step(1);
      link_up = 1; c0 = cyc;
      expect_req(0, c0 + 2);
      step(2);
      ver_tx = 1; step(1); ver_tx = 0;
      chk("R6 verifying again", status, 2);
      pmac_en = 0; rsp_rx = 1; step(1); rsp_rx = 0;
      chk("R10 response ignored with pMAC off", status, 2);
      link_up = 0;
      step(4*N);
      chk("R11 no attempts while down", exp_q.size(), 0);
      chk("R11 preempt low", preempt_en, 0);
      link_up = 1;
      step(2);
      chk("R10 no restart without pMAC", status, 2);
      chk("R12 irq off without pMAC", irq_en, 0);
      pmac_en = 1; c0 = cyc;
      expect_req(0, c0 + 1);
      expect_req(0, c0 + 1 + N);
      step(2*N + 1);
      chk("R10 budget kept, then failed", status, 4);
      step(10);
      chk("R10 all expected requests seen", exp_q.size(), 0);

      summary();
      $finish;
   end
endmodule